// File: doc/BRIEF.md
# Multi-Channel Down-Counter Timer Register Block

This block is the register front end of a small timer unit holding two or three down-counting channels. A word-addressed byte-offset bus reaches a shared pin-direction register, a shared run register with one bit per channel, and a window of registers for each channel. The address space is laid out as follows:

- Channel windows are 12 bytes apart, starting at offset 0x08.
- Each window holds a reload value, a live count and a control word.
- The third channel also has a capture register at offset 0x2C.

Each channel divides the block clock by a selectable power of four. At every divided tick it decrements its count. When the count reaches zero it reloads and raises an underflow flag, which can drive that channel's interrupt output.

Two build-time switches set the unit's size:

- `HAS_CH2` removes the third channel, together with its input capture.
- `HAS_OUTCTL` removes the pin-direction register.

An access to an address that is not implemented returns zero and changes nothing. It also raises an error pulse.

Top module: `tmu_regblk`

## Requirements
- R1: After reset every reload and count register reads 0xFFFFFFFF. Every control word, the capture register, the run register and the pin-direction register read 0. `irq`, `bus_err` and `tclk_dir` are low.
- R2: Only word-aligned offsets decode. The address map is:
  - 0x00: pin-direction register.
  - 0x04: run register.
  - Channel n (n = 0, 1, 2) occupies 0x08+12n (reload), 0x0C+12n (count) and 0x10+12n (control).
  - 0x2C: capture register of channel 2.
- R3: Run bit n (bit 0, 1, 2) starts channel n when 1 and stops it when 0. The register reads back the written run bits, with the bit of any absent channel forced to 0 and bits 31..3 read as 0.
- R4: Control bits 2..0 (select s) set the tick period. For s = 0 to 4 the period is 4<<(2s) clocks; for s = 5, 6 and 7 it is 1024 clocks. Each tick decrements a running channel's count by one. The first tick falls one full period after the run bit is set, and a control write restarts the period.
- R5: A tick that finds the count at 0 loads the reload value and sets the underflow flag (control bit 8). A write to the count register wins over a tick in the same cycle.
- R6: Clearing a run bit freezes the count and the position within the current tick period. Setting the bit again resumes from both.
- R7: Control bit 5 enables the interrupt. `irq[n]` is high while channel n has its underflow flag set and bit 5 set. A control write with bit 8 = 0 clears the flag; with bit 8 = 1 the flag is left unchanged.
- R8: Channel 2 only (the other channels read these bits as 0):
  - Control bits 7..6 select capture, which is on when bit 7 is 1.
  - With capture on, a rising edge of `cap_in` copies the count into the capture register and sets the capture flag (control bit 9).
  - With bits 7..6 = 11, the capture flag also drives `irq[2]`.
  - A control write with bit 9 = 0 clears the capture flag.
- R9: The pin-direction register stores only bit 0 and drives `tclk_dir` from it. Its other bits read 0.
- R10: An access is invalid if it is unaligned, beyond 0x2C, to 0x00 without `HAS_OUTCTL`, or to 0x20 or above without `HAS_CH2`. An invalid read returns 0 and an invalid write changes no register. Either access raises `bus_err` for exactly the one cycle after it.
- R11: Without `HAS_CH2`, writing run bit 2 as 1 raises `bus_err`, while run bits 0 and 1 of the same write still take effect.
- R12: Read data is registered. It appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| cap_in | input | 1 | Capture trigger for channel 2, rising edge |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an invalid access |
| tclk_dir | output | 1 | Timer clock pin direction |
| irq | output | 3 | Per-channel interrupt requests |

## Verification
A wrong internal state shows up in different places depending on where it sits:

- A wrong prescaler phase or count shows as a wrong count value on the first read after a stop. The bench sets run windows of exact length, so a single extra or missing tick is visible.
- A paused channel that keeps its phase is told apart from one that resets it by a two-cycle resume that must produce exactly one tick.
- A wrong flag or enable shows on `irq` one cycle after the event that set or cleared it.
- A decode error shows on `bus_err` and `bus_rdata` in the cycle right after the access. Such an error also leaves a neighbouring register, read back afterwards, unchanged.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int MAX_CH   = 3;
    localparam int PRESC_W  = 10;

    localparam logic [ADDR_W-1:0] OFS_PINDIR = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RUN    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_WIN0   = 8'h08;
    localparam logic [ADDR_W-1:0] WIN_STRIDE = 8'd12;
    localparam logic [ADDR_W-1:0] OFS_CAPT   = 8'h2C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PINDIR,
        SEL_RUN,
        SEL_RELOAD,
        SEL_COUNT,
        SEL_CTRL,
        SEL_CAPT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e    sel;
        logic [1:0]  ch;
        logic        valid;
    } decode_t;

    // control word layout, msb first: bit9 capture flag, bit8 underflow flag,
    // bits7..6 capture mode, bit5 interrupt enable, bits4..3 unused, bits2..0 select
    typedef struct packed {
        logic        capf;
        logic        uf;
        logic [1:0]  capmode;
        logic        irq_en;
        logic [1:0]  rsvd;
        logic [2:0]  psel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [3:0] presc_log2(input logic [2:0] psel);
        if (psel <= 3'd4) return 4'd2 + {psel, 1'b0};
        return 4'd10;
    endfunction

endpackage

// File: rtl/tmu_addr_dec.sv
module tmu_addr_dec
    import tmu_pkg::*;
#(
    parameter bit HAS_CH2    = 1'b1,
    parameter bit HAS_OUTCTL = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    localparam logic [ADDR_W-1:0] NUM_CH = HAS_CH2 ? 8'd3 : 8'd2;
    localparam logic [ADDR_W-1:0] WIN_END = OFS_WIN0 + NUM_CH * WIN_STRIDE;

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] ch_idx;
    logic [ADDR_W-1:0] slot;

    always_comb begin
        off    = addr - OFS_WIN0;
        ch_idx = off / WIN_STRIDE;
        slot   = (off - ch_idx * WIN_STRIDE) >> 2;
        dec    = '{sel: SEL_NONE, ch: 2'd0, valid: 1'b0};
        if (addr[1:0] == 2'b00) begin
            if (addr == OFS_PINDIR) begin
                if (HAS_OUTCTL) dec.sel = SEL_PINDIR;
            end else if (addr == OFS_RUN) begin
                dec.sel = SEL_RUN;
            end else if (addr >= OFS_WIN0 && addr < WIN_END) begin
                dec.ch = ch_idx[1:0];
                case (slot[1:0])
                    2'd0:    dec.sel = SEL_RELOAD;
                    2'd1:    dec.sel = SEL_COUNT;
                    default: dec.sel = SEL_CTRL;
                endcase
            end else if (HAS_CH2 && addr == OFS_CAPT) begin
                dec.sel = SEL_CAPT;
                dec.ch  = 2'd2;
            end
        end
        dec.valid = (dec.sel != SEL_NONE);
    end

endmodule

// File: rtl/tmu_presc.sv
module tmu_presc
    import tmu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clr,
    input  logic [2:0] psel,
    output logic       tick
);
    logic [PRESC_W-1:0] phase_q;
    logic [PRESC_W:0]   span;
    logic [PRESC_W:0]   lim_w;
    logic [PRESC_W-1:0] lim;

    always_comb begin
        span  = (PRESC_W+1)'(1) << presc_log2(psel);
        lim_w = span - (PRESC_W+1)'(1);
        lim   = lim_w[PRESC_W-1:0];
        tick  = run && (phase_q == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == lim) ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmu_chan.sv
module tmu_chan
    import tmu_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter bit CAPT  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              wr_reload,
    input  logic              wr_count,
    input  logic              wr_ctrl,
    input  logic              wr_capt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cap_in,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  reload,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  capt,
    output logic              irq
);
    logic  tick;
    logic  cap_prev;
    logic  uf_evt;
    logic  cap_evt;
    ctrl_t w;

    tmu_presc u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .clr  (wr_ctrl),
        .psel (ctrl.psel),
        .tick (tick)
    );

    always_comb begin
        w       = ctrl_t'(wdata[CTRL_W-1:0]);
        uf_evt  = tick && (count == '0) && !wr_count;
        cap_evt = CAPT && ctrl.capmode[1] && cap_in && !cap_prev;
        irq     = (ctrl.uf && ctrl.irq_en)
                || (CAPT && ctrl.capf && (ctrl.capmode == 2'b11));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '1;
            reload   <= '1;
            ctrl     <= '0;
            capt     <= '0;
            cap_prev <= 1'b0;
        end else begin
            cap_prev <= cap_in;

            if (wr_count)      count <= wdata[CNT_W-1:0];
            else if (tick)     count <= (count == '0) ? reload : count - 1'b1;

            if (wr_reload)     reload <= wdata[CNT_W-1:0];

            if (wr_ctrl) begin
                ctrl.psel    <= w.psel;
                ctrl.irq_en  <= w.irq_en;
                ctrl.capmode <= CAPT ? w.capmode : 2'b00;
            end
            ctrl.uf   <= (wr_ctrl ? (ctrl.uf && w.uf) : ctrl.uf) || uf_evt;
            ctrl.capf <= CAPT && ((wr_ctrl ? (ctrl.capf && w.capf) : ctrl.capf) || cap_evt);
            ctrl.rsvd <= 2'b00;

            if (cap_evt)             capt <= count;
            else if (CAPT && wr_capt) capt <= wdata[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/tmu_regblk.sv
module tmu_regblk
    import tmu_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter bit HAS_CH2    = 1'b1,
    parameter bit HAS_OUTCTL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              cap_in,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              tclk_dir,
    output logic [MAX_CH-1:0] irq
);
    localparam int NUM_CH = HAS_CH2 ? 3 : 2;
    localparam logic [MAX_CH-1:0] RUN_MASK = MAX_CH'((1 << NUM_CH) - 1);

    decode_t           dec;
    logic [MAX_CH-1:0] start_q;
    logic              pindir_q;
    logic              run_bad;
    logic [DATA_W-1:0] rd_val;

    logic [CNT_W-1:0]  cnt_arr  [MAX_CH];
    logic [CNT_W-1:0]  rel_arr  [MAX_CH];
    logic [CNT_W-1:0]  capt_arr [MAX_CH];
    ctrl_t             ctrl_arr [MAX_CH];

    tmu_addr_dec #(.HAS_CH2(HAS_CH2), .HAS_OUTCTL(HAS_OUTCTL)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar g = 0; g < MAX_CH; g++) begin : g_ch
        if (g < NUM_CH) begin : g_on
            logic wr_hit;
            assign wr_hit = bus_wr && dec.valid && (dec.ch == 2'(g));
            tmu_chan #(.CNT_W(CNT_W), .CAPT(g == 2)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .run       (start_q[g]),
                .wr_reload (wr_hit && dec.sel == SEL_RELOAD),
                .wr_count  (wr_hit && dec.sel == SEL_COUNT),
                .wr_ctrl   (wr_hit && dec.sel == SEL_CTRL),
                .wr_capt   (wr_hit && dec.sel == SEL_CAPT),
                .wdata     (bus_wdata),
                .cap_in    (cap_in),
                .count     (cnt_arr[g]),
                .reload    (rel_arr[g]),
                .ctrl      (ctrl_arr[g]),
                .capt      (capt_arr[g]),
                .irq       (irq[g])
            );
        end else begin : g_off
            assign cnt_arr[g]  = '0;
            assign rel_arr[g]  = '0;
            assign capt_arr[g] = '0;
            assign ctrl_arr[g] = '0;
            assign irq[g]      = 1'b0;
        end
    end

    always_comb begin
        run_bad = bus_wr && (dec.sel == SEL_RUN) && !HAS_CH2 && bus_wdata[2];
        rd_val  = '0;
        case (dec.sel)
            SEL_PINDIR: rd_val[0]               = pindir_q;
            SEL_RUN:    rd_val[MAX_CH-1:0]      = start_q;
            SEL_RELOAD: rd_val[CNT_W-1:0]       = rel_arr[dec.ch];
            SEL_COUNT:  rd_val[CNT_W-1:0]       = cnt_arr[dec.ch];
            SEL_CTRL:   rd_val[CTRL_W-1:0]      = ctrl_arr[dec.ch];
            SEL_CAPT:   rd_val[CNT_W-1:0]       = capt_arr[dec.ch];
            default:    rd_val                  = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q   <= '0;
            pindir_q  <= 1'b0;
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            if (bus_wr && dec.sel == SEL_RUN)    start_q  <= bus_wdata[MAX_CH-1:0] & RUN_MASK;
            if (bus_wr && dec.sel == SEL_PINDIR) pindir_q <= bus_wdata[0];
            if (bus_rd)                          bus_rdata <= rd_val;
            bus_err <= ((bus_wr || bus_rd) && !dec.valid) || run_bad;
        end
    end

    assign tclk_dir = pindir_q;

endmodule

// File: rtl/tmu_regblk_chk.sv
module tmu_regblk_chk
    import tmu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic              tclk_dir,
    input logic [MAX_CH-1:0] irq,
    input logic [MAX_CH-1:0] run,
    input logic [CNT_W-1:0]  cnt0,
    input logic [CNT_W-1:0]  rel0
);
    logic wr_win0;
    assign wr_win0 = bus_wr && (bus_addr >= 8'h08) && (bus_addr <= 8'h13);

    // R10
    err_only_after_access_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr || bus_rd) |=> !bus_err);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R9
    pindir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 8'h00) |=> $stable(tclk_dir));

    // R6
    paused_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run[0] && !wr_win0) |=> $stable(cnt0));

    // R4 R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run[0] && !wr_win0) |=> (cnt0 == $past(cnt0))
                              || (cnt0 == $past(cnt0) - CNT_W'(1))
                              || ($past(cnt0) == '0 && cnt0 == $past(rel0)));

    // R7
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq[1]) |-> ($past(run[1]) || $past(bus_wr)));

endmodule

bind tmu_regblk tmu_regblk_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .tclk_dir  (tclk_dir),
    .irq       (irq),
    .run       (start_q),
    .cnt0      (cnt_arr[0]),
    .rel0      (rel_arr[0])
);

// File: tb/tmu_regblk_test.sv
`timescale 1ns/1ps
module tmu_regblk_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0, rd = 1'b0, wr_m = 1'b0, rd_m = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        cap_in = 1'b0;
    logic [31:0] rdata, rdata_m;
    logic        err, err_m, dir, dir_m;
    logic [2:0]  irq, irq_m;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmu_regblk uut (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .cap_in(cap_in), .bus_rdata(rdata),
        .bus_err(err), .tclk_dir(dir), .irq(irq)
    );

    tmu_regblk #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0)) uut_min (
        .clk(clk), .rst(rst), .bus_wr(wr_m), .bus_rd(rd_m), .bus_addr(addr),
        .bus_wdata(wdata), .cap_in(cap_in), .bus_rdata(rdata_m),
        .bus_err(err_m), .tclk_dir(dir_m), .irq(irq_m)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    task automatic bus_write(input bit m, input logic [7:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        addr = a; wdata = d;
        if (m) wr_m = 1'b1; else wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wr_m = 1'b0;
        e = m ? err_m : err;
    endtask

    task automatic bus_read(input bit m, input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        addr = a;
        if (m) rd_m = 1'b1; else rd = 1'b1;
        @(negedge clk);
        rd = 1'b0; rd_m = 1'b0;
        d = m ? rdata_m : rdata;
        e = m ? err_m : err;
    endtask

    task automatic wr0(input logic [7:0] a, input logic [31:0] d);
        logic e;
        bus_write(1'b0, a, d, e);
    endtask

    task automatic rd0(input logic [7:0] a, output logic [31:0] d);
        logic e;
        bus_read(1'b0, a, d, e);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check_eq("R1 irq", {29'd0, irq}, 32'd0);
        check_eq("R1 err", {31'd0, err}, 32'd0);
        check_eq("R1 tclk_dir", {31'd0, dir}, 32'd0);
        rd0(8'h08, d); check_eq("R1 reload ch0", d, 32'hFFFF_FFFF);
        rd0(8'h18, d); check_eq("R1 count ch1", d, 32'hFFFF_FFFF);
        rd0(8'h28, d); check_eq("R1 ctrl ch2", d, 32'h0);
        rd0(8'h04, d); check_eq("R1 run reg", d, 32'h0);
        rd0(8'h2C, d); check_eq("R1 capture", d, 32'h0);
    endtask

    task automatic t_pindir();
        logic [31:0] d;
        wr0(8'h00, 32'hFFFF_FFFE);
        check_eq("R9 dir low", {31'd0, dir}, 32'd0);
        wr0(8'h00, 32'hFFFF_FFFF);
        check_eq("R9 dir high", {31'd0, dir}, 32'd1);
        rd0(8'h00, d); check_eq("R9 readback", d, 32'h1);
    endtask

    task automatic t_run_reg();
        logic [31:0] d;
        wr0(8'h04, 32'hFFFF_FFFF);
        rd0(8'h04, d); check_eq("R3 run readback", d, 32'h7);
        wr0(8'h04, 32'h0);
        rd0(8'h04, d); check_eq("R3 run cleared", d, 32'h0);
    endtask

    task automatic t_count_pause();
        logic [31:0] d;
        wr0(8'h10, 32'h0);
        wr0(8'h0C, 32'd7);
        wr0(8'h04, 32'h1);
        repeat (10) @(negedge clk);
        wr0(8'h04, 32'h0);
        rd0(8'h0C, d); check_eq("R4 three ticks div4", d, 32'd4);
        repeat (20) @(negedge clk);
        rd0(8'h0C, d); check_eq("R6 paused count held", d, 32'd4);
        wr0(8'h04, 32'h1);
        repeat (5) @(negedge clk);
        wr0(8'h04, 32'h0);
        rd0(8'h0C, d); check_eq("R6 resume one tick", d, 32'd3);
        wr0(8'h04, 32'h1);
        wr0(8'h04, 32'h0);
        rd0(8'h0C, d); check_eq("R6 phase kept on resume", d, 32'd2);
    endtask

    task automatic t_prescale();
        logic [31:0] d;
        wr0(8'h1C, 32'h1);
        wr0(8'h18, 32'd100);
        wr0(8'h04, 32'h2);
        repeat (30) @(negedge clk);
        wr0(8'h04, 32'h0);
        rd0(8'h18, d); check_eq("R4 div16 two ticks", d, 32'd98);
        wr0(8'h1C, 32'h5);
        wr0(8'h18, 32'd100);
        wr0(8'h04, 32'h2);
        repeat (2046) @(negedge clk);
        wr0(8'h04, 32'h0);
        rd0(8'h18, d); check_eq("R4 select 5 as div1024", d, 32'd98);
    endtask

    task automatic t_underflow();
        logic [31:0] d;
        wr0(8'h1C, 32'h20);
        wr0(8'h14, 32'd3);
        wr0(8'h18, 32'd1);
        wr0(8'h04, 32'h2);
        repeat (10) @(negedge clk);
        wr0(8'h04, 32'h0);
        rd0(8'h18, d); check_eq("R5 reload after zero", d, 32'd2);
        rd0(8'h1C, d); check_eq("R5 R7 flag and enable", d, 32'h120);
        check_eq("R7 irq1 raised", {29'd0, irq}, 32'h2);
        wr0(8'h1C, 32'h120);
        check_eq("R7 write one keeps flag", {29'd0, irq}, 32'h2);
        wr0(8'h1C, 32'h020);
        check_eq("R7 write zero clears", {29'd0, irq}, 32'h0);
    endtask

    task automatic t_capture();
        logic [31:0] d;
        wr0(8'h28, 32'hC0);
        wr0(8'h24, 32'h55);
        @(negedge clk); cap_in = 1'b1;
        @(negedge clk); cap_in = 1'b0;
        rd0(8'h2C, d); check_eq("R8 captured count", d, 32'h55);
        rd0(8'h28, d); check_eq("R8 capture flag", d, 32'h2C0);
        check_eq("R8 irq2", {29'd0, irq}, 32'h4);
        wr0(8'h28, 32'h0C0);
        check_eq("R8 flag cleared", {29'd0, irq}, 32'h0);
        wr0(8'h10, 32'h3C0);
        rd0(8'h10, d); check_eq("R8 ch0 has no capture bits", d, 32'h0);
    endtask

    task automatic t_invalid();
        logic [31:0] d;
        logic e;
        bus_read(1'b0, 8'h30, d, e);
        check_eq("R10 read past map data", d, 32'h0);
        check_eq("R10 read past map err", {31'd0, e}, 32'd1);
        @(negedge clk);
        check_eq("R10 err one cycle", {31'd0, err}, 32'd0);
        bus_write(1'b0, 8'h09, 32'h5, e);
        check_eq("R10 unaligned write err", {31'd0, e}, 32'd1);
        rd0(8'h08, d); check_eq("R10 unaligned write ignored", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr0(8'h20, 32'hA5A5);
        rd0(8'h20, d); check_eq("R2 ch2 reload", d, 32'hA5A5);
        rd0(8'h08, d); check_eq("R2 ch0 reload untouched", d, 32'hFFFF_FFFF);
        @(negedge clk); @(negedge clk);
        check_eq("R12 rdata held", rdata, 32'hFFFF_FFFF);
    endtask

    task automatic t_min();
        logic [31:0] d;
        logic e;
        bus_read(1'b1, 8'h00, d, e);
        check_eq("R10 no pindir err", {31'd0, e}, 32'd1);
        bus_read(1'b1, 8'h20, d, e);
        check_eq("R10 no ch2 err", {31'd0, e}, 32'd1);
        check_eq("R10 no ch2 data", d, 32'h0);
        bus_write(1'b1, 8'h04, 32'h7, e);
        check_eq("R11 run bit2 err", {31'd0, e}, 32'd1);
        bus_read(1'b1, 8'h04, d, e);
        check_eq("R11 run bits 0 1 kept", d, 32'h3);
        check_eq("R11 run read no err", {31'd0, e}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pindir();
        t_run_reg();
        t_count_pause();
        t_prescale();
        t_underflow();
        t_capture();
        t_invalid();
        t_map();
        t_min();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule